// File: doc/BRIEF.md
# NAND Flash Command Front-End

This block is a synthesizable device-side model of a small NAND flash part. A host drives a shared 8-bit bus together with command-latch, address-latch, write-enable, read-enable, chip-enable and write-protect lines. The model samples the bus on each rising edge of write enable and uses the two latch lines to decide whether the byte is a command, an address byte or a data byte. Each falling edge of read enable presents one byte on the output: from a 32-byte frame register, from a status byte or from an identification sequence. A ready/busy output stays low for a parameterized number of system clock cycles while a frame fetch, program, erase or reset is in progress.

The cell array is an on-chip memory of whole frames. Only the low block and row bits of the 19-bit address select a frame, so higher addresses alias onto the stored part. Programming combines new data with old data using AND. Erase sets every frame of the addressed block back to FFh.

Top module: `nandfe_top`

## Requirements
- R1: After reset, rdyBsy is 1 and the bus is in array-read mode. Every frame of the array holds FFh, and the frame register holds FFh.
- R2: A bus cycle is taken only on a rising edge of weN while ceN is low. cle=1, ale=0 marks a command. ale=1, cle=0 marks an address byte. cle=0, ale=0 marks a data byte. A data byte of 70h is not treated as a command, and a cycle with ceN high is ignored.
- R3: Command 00h followed by three address bytes starts a frame fetch. The address bytes come low byte first and carry bits 7:0, 15:8 and 18:16. Bits 4:0 select the column, 6:5 the frame, 11:7 the row and 18:12 the block. rdyBsy is low for READ_CYC cycles. Each read-enable falling edge then returns the byte at the current column and advances the column. Reads past column 31 return FFh.
- R4: Command 80h fills the frame register with FFh. Three address bytes follow, then data bytes that are stored from the starting column upward. Command 10h then keeps rdyBsy low for PROG_CYC cycles. At the end, the addressed frame becomes the old contents AND the frame register, so bytes that were not loaded stay unchanged.
- R5: A 10h with no data byte loaded since the 80h sequence leaves rdyBsy high and the array unchanged.
- R6: Command 60h, two address bytes (bits 15:8 then 18:16), then D0h keeps rdyBsy low for ERASE_CYC cycles and sets the whole block selected by bits 18:12 to FFh. Bits 11:8 are ignored, and other blocks are untouched.
- R7: After 70h, every read returns status and keeps doing so until another command is accepted. The status bits are: bit 7 = wpN, bit 6 = 1 when ready and 0 when busy, bits 5:1 = 0, bit 0 = 1 if the last confirm was refused by write protect. Program and erase confirms also select status.
- R8: Command 90h followed by one address byte makes the next reads return ECh, then A4h, then 00h.
- R9: While busy, only 70h and FFh are accepted. Other commands, address bytes and data bytes have no effect.
- R10: FFh drives rdyBsy low for RST_CYC cycles, aborts any program or erase in progress without completing it, and returns to array-read mode. An FFh that arrives during a reset interval is ignored.
- R11: With wpN low, 10h and D0h start nothing: rdyBsy stays high and the array is unchanged. Status bit 0 becomes 1. A program that does start clears status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all bus lines |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| cle | input | 1 | Marks the current write cycle as a command |
| ale | input | 1 | Marks the current write cycle as an address byte |
| weN | input | 1 | Write enable, active low, taken on its rising edge |
| reN | input | 1 | Read enable, active low, a byte on each falling edge |
| wpN | input | 1 | Write protect, active low |
| ioIn | input | 8 | Bus byte driven by the host |
| ioOut | output | 8 | Byte presented by the device |
| ioOe | output | 1 | High while the device drives the bus |
| rdyBsy | output | 1 | 1 = ready, 0 = busy |

## Verification
The bench aims at ordering corners. A partial re-program into a frame that already holds data exposes a design that overwrites instead of ANDing, because the result byte comes back wrong. A confirm with no data, a refused confirm under write protect, and commands sent during an erase would each start work or change the output mode in a faulty design; the bench sees this on rdyBsy or in the next status byte. A reset in the middle of a program must leave the frame erased, and an erase with junk in bits 11:8 must clear only its own block. Reads past the end of the frame and the third ID read show whether the column counter and ID counter saturate or wrap.

// File: rtl/nandfe_pkg.sv
package nandfe_pkg;
  localparam int FRAME_BYTES = 32;
  localparam int COL_W = 5;

  localparam logic [7:0] CMD_READ     = 8'h00;
  localparam logic [7:0] CMD_RESET    = 8'hFF;
  localparam logic [7:0] CMD_PROG     = 8'h80;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_ID       = 8'h90;
  localparam logic [7:0] ID_MAKER     = 8'hEC;
  localparam logic [7:0] ID_DEVICE    = 8'hA4;

  typedef enum logic [2:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE, OP_ID} opT;
  typedef enum logic [1:0] {OUT_ARRAY, OUT_STATUS, OUT_ID} outModeT;
  typedef enum logic [1:0] {BK_READ, BK_PROG, BK_ERASE, BK_RESET} busyKindT;

  // strobes from control to datapath
  typedef struct packed {
    logic clrFrame;
    logic wrByte;
    logic loadFrame;
    logic setCol;
    logic commit;
    logic eraseWr;
    logic rdAdv;
    logic rdAlt;
  } strobeT;
endpackage

// File: rtl/nandfe_data.sv
module nandfe_data
  import nandfe_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic [IDX_W-1:0] frameIdx,
  input  logic [COL_W-1:0] colStart,
  input  logic [7:0]       dataIn,
  input  logic [7:0]       altByte,
  output logic [7:0]       dout
);
  localparam int DEPTH   = 1 << IDX_W;
  localparam int FRAME_W = FRAME_BYTES * 8;

  logic [FRAME_W-1:0] mem [DEPTH];
  logic [7:0]         frameReg [FRAME_BYTES];
  logic [FRAME_W-1:0] framePacked;
  logic [FRAME_W-1:0] memRd;
  logic [COL_W:0]     col;
  logic               colInRange;
  logic [7:0]         doutQ;

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : gPack
    assign framePacked[g*8 +: 8] = frameReg[g];
  end

  assign memRd      = mem[frameIdx];
  assign colInRange = !col[COL_W];
  assign dout       = doutQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < FRAME_BYTES; i++) frameReg[i] <= 8'hFF;
      col   <= '0;
      doutQ <= 8'hFF;
    end else begin
      if (strb.clrFrame) begin
        for (int i = 0; i < FRAME_BYTES; i++) frameReg[i] <= 8'hFF;
      end else if (strb.loadFrame) begin
        for (int i = 0; i < FRAME_BYTES; i++) frameReg[i] <= memRd[i*8 +: 8];
      end else if (strb.wrByte && colInRange) begin
        frameReg[col[COL_W-1:0]] <= dataIn;
      end

      if (strb.setCol) col <= {1'b0, colStart};
      else if ((strb.wrByte || strb.rdAdv) && colInRange) col <= col + 1'b1;

      if (strb.rdAdv) doutQ <= colInRange ? frameReg[col[COL_W-1:0]] : 8'hFF;
      else if (strb.rdAlt) doutQ <= altByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.commit) begin
      mem[frameIdx] <= memRd & framePacked;
    end else if (strb.eraseWr) begin
      mem[frameIdx] <= '1;
    end
  end
endmodule

// File: rtl/nandfe_ctrl.sv
module nandfe_ctrl
  import nandfe_pkg::*;
#(
  parameter int BLK_BITS  = 1,
  parameter int ROW_BITS  = 2,
  parameter int READ_CYC  = 8,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 80,
  parameter int RST_CYC   = 6,
  localparam int IDX_W    = BLK_BITS + ROW_BITS + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEdge,
  input  logic             reEvent,
  input  logic             cle,
  input  logic             ale,
  input  logic             wpN,
  input  logic [7:0]       ioIn,
  output strobeT           strb,
  output logic [IDX_W-1:0] frameIdx,
  output logic [COL_W-1:0] colStart,
  output logic [7:0]       altByte,
  output logic             busy
);
  localparam int FR_BITS = ROW_BITS + 2;
  localparam int MAX_AB  = (READ_CYC > PROG_CYC) ? READ_CYC : PROG_CYC;
  localparam int MAX_CD  = (ERASE_CYC > RST_CYC) ? ERASE_CYC : RST_CYC;
  localparam int MAX_C   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_C + 1);

  opT                 op;
  outModeT            outMode;
  busyKindT           busyKind;
  logic [1:0]         addrCnt;
  logic [18:0]        addrQ;
  logic [CNT_W-1:0]   busyCnt;
  logic [FR_BITS:0]   eraseCnt;
  logic [1:0]         idIdx;
  logic               failQ;
  logic               loadedQ;

  logic isCmd, isAddr, isData, doneNow;
  logic [IDX_W-1:0] addrIdx, eraseIdx;
  logic [7:0] statusByte;

  assign isCmd   = wrEdge && cle && !ale;
  assign isAddr  = wrEdge && ale && !cle;
  assign isData  = wrEdge && !ale && !cle;
  assign busy    = busyCnt != '0;
  assign doneNow = busyCnt == CNT_W'(1);

  assign addrIdx  = {addrQ[12 +: BLK_BITS], addrQ[7 +: ROW_BITS], addrQ[6:5]};
  assign eraseIdx = {addrQ[12 +: BLK_BITS], eraseCnt[FR_BITS-1:0]};
  assign colStart = addrQ[COL_W-1:0];
  assign statusByte = {wpN, !busy, 5'b0, failQ};

  always_comb begin
    strb = '0;
    strb.eraseWr   = busy && busyKind == BK_ERASE && !eraseCnt[FR_BITS];
    strb.commit    = doneNow && busyKind == BK_PROG;
    strb.loadFrame = doneNow && busyKind == BK_READ;
    strb.clrFrame  = !busy && isCmd && ioIn == CMD_PROG;
    strb.wrByte    = !busy && isData && op == OP_PROG && addrCnt == 2'd3;
    strb.setCol    = strb.loadFrame ||
                     (!busy && isAddr && op == OP_PROG && addrCnt == 2'd2);
    strb.rdAdv     = reEvent && outMode == OUT_ARRAY && !busy;
    strb.rdAlt     = reEvent && !strb.rdAdv;

    frameIdx = (busy && busyKind == BK_ERASE) ? eraseIdx : addrIdx;

    case (outMode)
      OUT_STATUS: altByte = statusByte;
      OUT_ID:     altByte = (idIdx == 2'd0) ? ID_MAKER :
                            (idIdx == 2'd1) ? ID_DEVICE : 8'h00;
      default:    altByte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op       <= OP_NONE;
      outMode  <= OUT_ARRAY;
      busyKind <= BK_READ;
      addrCnt  <= '0;
      addrQ    <= '0;
      busyCnt  <= '0;
      eraseCnt <= '0;
      idIdx    <= '0;
      failQ    <= 1'b0;
      loadedQ  <= 1'b0;
    end else begin
      if (busy) busyCnt <= busyCnt - 1'b1;
      if (strb.eraseWr) eraseCnt <= eraseCnt + 1'b1;
      if (reEvent && outMode == OUT_ID && idIdx != 2'd2) idIdx <= idIdx + 1'b1;

      if (isCmd && busy) begin
        if (ioIn == CMD_STATUS) begin
          outMode <= OUT_STATUS;
        end else if (ioIn == CMD_RESET && busyKind != BK_RESET) begin
          busyKind <= BK_RESET;
          busyCnt  <= CNT_W'(RST_CYC);
          outMode  <= OUT_ARRAY;
          op       <= OP_NONE;
        end
      end else if (isCmd) begin
        case (ioIn)
          CMD_READ: begin
            op      <= OP_READ;
            addrCnt <= '0;
            outMode <= OUT_ARRAY;
          end
          CMD_PROG: begin
            op      <= OP_PROG;
            addrCnt <= '0;
            loadedQ <= 1'b0;
          end
          CMD_PROG_GO: begin
            op <= OP_NONE;
            if (op == OP_PROG && addrCnt == 2'd3 && loadedQ) begin
              outMode <= OUT_STATUS;
              if (wpN) begin
                busyKind <= BK_PROG;
                busyCnt  <= CNT_W'(PROG_CYC);
                failQ    <= 1'b0;
              end else begin
                failQ <= 1'b1;
              end
            end
          end
          CMD_ERASE: begin
            op      <= OP_ERASE;
            addrCnt <= '0;
            addrQ   <= '0;
          end
          CMD_ERASE_GO: begin
            op <= OP_NONE;
            if (op == OP_ERASE && addrCnt == 2'd2) begin
              outMode <= OUT_STATUS;
              if (wpN) begin
                busyKind <= BK_ERASE;
                busyCnt  <= CNT_W'(ERASE_CYC);
                eraseCnt <= '0;
              end else begin
                failQ <= 1'b1;
              end
            end
          end
          CMD_STATUS: outMode <= OUT_STATUS;
          CMD_ID: begin
            op      <= OP_ID;
            addrCnt <= '0;
          end
          CMD_RESET: begin
            busyKind <= BK_RESET;
            busyCnt  <= CNT_W'(RST_CYC);
            outMode  <= OUT_ARRAY;
            op       <= OP_NONE;
          end
          default: op <= OP_NONE;
        endcase
      end else if (isAddr && !busy) begin
        case (op)
          OP_READ, OP_PROG: begin
            if (addrCnt != 2'd3) begin
              addrCnt <= addrCnt + 1'b1;
              case (addrCnt)
                2'd0:    addrQ[7:0]   <= ioIn;
                2'd1:    addrQ[15:8]  <= ioIn;
                default: addrQ[18:16] <= ioIn[2:0];
              endcase
              if (addrCnt == 2'd2 && op == OP_READ) begin
                busyKind <= BK_READ;
                busyCnt  <= CNT_W'(READ_CYC);
                op       <= OP_NONE;
              end
            end
          end
          OP_ERASE: begin
            if (addrCnt == 2'd0) begin
              addrQ[15:8] <= ioIn;
              addrCnt     <= 2'd1;
            end else if (addrCnt == 2'd1) begin
              addrQ[18:16] <= ioIn[2:0];
              addrCnt      <= 2'd2;
            end
          end
          OP_ID: begin
            outMode <= OUT_ID;
            idIdx   <= '0;
            op      <= OP_NONE;
          end
          default: ;
        endcase
      end else if (strb.wrByte) begin
        loadedQ <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nandfe_top.sv
module nandfe_top
  import nandfe_pkg::*;
#(
  parameter int BLK_BITS  = 1,
  parameter int ROW_BITS  = 2,
  parameter int READ_CYC  = 8,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 80,
  parameter int RST_CYC   = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cle,
  input  logic       ale,
  input  logic       weN,
  input  logic       reN,
  input  logic       wpN,
  input  logic [7:0] ioIn,
  output logic [7:0] ioOut,
  output logic       ioOe,
  output logic       rdyBsy
);
  localparam int IDX_W = BLK_BITS + ROW_BITS + 2;

  logic weNQ, reNQ, wrEdge, reEvent, busy;
  strobeT strb;
  logic [IDX_W-1:0] frameIdx;
  logic [COL_W-1:0] colStart;
  logic [7:0] altByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weNQ <= 1'b1;
      reNQ <= 1'b1;
    end else begin
      weNQ <= weN;
      reNQ <= reN;
    end
  end

  assign wrEdge  = weN && !weNQ && !ceN;
  assign reEvent = !reN && reNQ && !ceN;
  assign ioOe    = !ceN && !reN;
  assign rdyBsy  = !busy;

  nandfe_ctrl #(
    .BLK_BITS(BLK_BITS), .ROW_BITS(ROW_BITS), .READ_CYC(READ_CYC),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .RST_CYC(RST_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEdge(wrEdge), .reEvent(reEvent),
    .cle(cle), .ale(ale), .wpN(wpN), .ioIn(ioIn),
    .strb(strb), .frameIdx(frameIdx), .colStart(colStart),
    .altByte(altByte), .busy(busy)
  );

  nandfe_data #(.IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .frameIdx(frameIdx),
    .colStart(colStart), .dataIn(ioIn), .altByte(altByte), .dout(ioOut)
  );
endmodule

// File: rtl/nandfe_chk.sv
module nandfe_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       cle,
  input logic       ale,
  input logic       weN,
  input logic       reN,
  input logic       wpN,
  input logic [7:0] ioIn,
  input logic [7:0] ioOut,
  input logic       rdyBsy
);
  logic wePrev, rePrev, wrSeen, rdSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wePrev <= 1'b1;
      rePrev <= 1'b1;
    end else begin
      wePrev <= weN;
      rePrev <= reN;
    end
  end

  assign wrSeen = weN && !wePrev && !ceN;
  assign rdSeen = !reN && rePrev && !ceN;

  // R9: busy can only begin on an accepted write cycle
  assert_busy_from_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyBsy) |-> $past(wrSeen));

  // R3: the output byte moves only after a read-enable falling edge
  assert_out_on_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ioOut != $past(ioOut)) |-> $past(rdSeen));

  // R11: a confirm under write protect never starts work
  assert_wp_blocks_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyBsy) |-> !($past(cle) && !$past(wpN) &&
                        ($past(ioIn) == 8'h10 || $past(ioIn) == 8'hD0)));

  // R10: reset command while ready enters busy
  assert_reset_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrSeen && cle && !ale && ioIn == 8'hFF && rdyBsy) |=> !rdyBsy);
endmodule

bind nandfe_top nandfe_chk uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN),
  .reN(reN), .wpN(wpN), .ioIn(ioIn), .ioOut(ioOut), .rdyBsy(rdyBsy)
);

// File: tb/tb_nandfe_top.sv
`timescale 1ns/1ps
module tb_nandfe_top;
  localparam int RD = 4;
  localparam int PG = 6;
  localparam int ER = 20;
  localparam int RS = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b0, cle = 1'b0, ale = 1'b0, weN = 1'b1, reN = 1'b1, wpN = 1'b1;
  logic [7:0] ioIn = 8'h00;
  logic [7:0] ioOut;
  logic ioOe, rdyBsy;

  int total = 0;
  int bad = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  nandfe_top #(.BLK_BITS(1), .ROW_BITS(2), .READ_CYC(RD), .PROG_CYC(PG),
               .ERASE_CYC(ER), .RST_CYC(RS)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN),
    .reN(reN), .wpN(wpN), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe),
    .rdyBsy(rdyBsy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: compare each byte read against the scoreboard queue
  logic reSeen = 1'b1;
  always @(negedge clk) begin
    if (reSeen && !reN) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL unexpected read act=%0h exp=none", ioOut);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(ioOut == e, t, ioOut, e);
      end
    end
    reSeen = reN;
  end

  task automatic wr(input logic c, input logic a, input logic [7:0] d, input logic ce = 1'b0);
    @(negedge clk); #1;
    cle = c; ale = a; ioIn = d; ceN = ce; weN = 1'b0;
    @(negedge clk); #1;
    weN = 1'b1;
    @(negedge clk); #1;
    cle = 1'b0; ale = 1'b0; ceN = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);  wr(1'b1, 1'b0, d); endtask
  task automatic adr(input logic [7:0] d);  wr(1'b0, 1'b1, d); endtask
  task automatic dat(input logic [7:0] d);  wr(1'b0, 1'b0, d); endtask
  task automatic adr3(input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2);
    adr(a0); adr(a1); adr(a2);
  endtask

  task automatic expRd(input logic [7:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk); #1;
    reN = 1'b0;
    @(negedge clk); #1;
    reN = 1'b1;
  endtask

  // counts busy cycles; exp < 0 skips the length check
  task automatic waitReady(input int exp, input string tag);
    int cnt = 0;
    while (!rdyBsy && cnt < 1000) begin
      cnt++;
      @(negedge clk); #1;
    end
    if (exp >= 0) check(cnt == exp, tag, cnt, exp);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'h3C + 8'(i * 19);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    check(rdyBsy == 1'b1, "R1 ready after reset", rdyBsy, 1);
    cmd(8'h70);
    expRd(8'hC0, "R7 status after reset");
    cmd(8'h00); adr3(8'hC0, 8'h10, 8'h00);
    waitReady(RD, "R3 fetch busy length");
    expRd(8'hFF, "R1 erased array col0");
    expRd(8'hFF, "R1 erased array col1");

    // R4 program block1,row1,frame2 from column 3
    cmd(8'h80); adr3(8'hC3, 8'h10, 8'h00);
    for (int i = 0; i < 8; i++) dat(pat(i));
    cmd(8'h10);
    check(rdyBsy == 1'b0, "R4 busy after confirm", rdyBsy, 0);
    waitReady(PG, "R4 program busy length");
    expRd(8'hC0, "R7 status after program");
    expRd(8'hC0, "R7 status stays selected");

    // R3 read whole frame plus one beyond the end
    cmd(8'h00); adr3(8'hC0, 8'h10, 8'h00);
    waitReady(RD, "R3 fetch busy length");
    for (int j = 0; j < 33; j++) begin
      if (j >= 3 && j < 11) expRd(pat(j - 3), "R3 frame byte");
      else expRd(8'hFF, "R3 frame byte or past end");
    end
    // R2 data byte 70h is not a command
    dat(8'h70);
    expRd(8'hFF, "R2 data cycle not taken as command");

    // R4 partial program: AND with old contents
    cmd(8'h80); adr3(8'hC3, 8'h10, 8'h00);
    dat(8'h0F);
    cmd(8'h10);
    waitReady(PG, "R4 second program busy length");
    cmd(8'h00); adr3(8'hC3, 8'h10, 8'h00);
    waitReady(RD, "R3 fetch busy length");
    expRd(pat(0) & 8'h0F, "R4 AND of old and new");
    expRd(pat(1), "R4 unloaded byte unchanged");

    // R5 confirm without data
    cmd(8'h80); adr3(8'hC0, 8'h10, 8'h00);
    cmd(8'h10);
    for (int k = 0; k < 3; k++) begin
      check(rdyBsy == 1'b1, "R5 no busy without data", rdyBsy, 1);
      @(negedge clk); #1;
    end

    // R6 erase block1 with junk in bits 11:8, block0 kept
    cmd(8'h80); adr3(8'h00, 8'h00, 8'h00); dat(8'h33); cmd(8'h10);
    waitReady(PG, "R4 program block0 busy length");
    cmd(8'h60); adr(8'h1F); adr(8'h00); cmd(8'hD0);
    waitReady(ER, "R6 erase busy length");
    cmd(8'h00); adr3(8'hC3, 8'h10, 8'h00);
    waitReady(RD, "R3 fetch busy length");
    expRd(8'hFF, "R6 erased block reads FF");
    cmd(8'h00); adr3(8'h00, 8'h00, 8'h00);
    waitReady(RD, "R3 fetch busy length");
    expRd(8'h33, "R6 other block untouched");

    // R9 command filter while busy
    cmd(8'h60); adr(8'h10); adr(8'h00); cmd(8'hD0);
    cmd(8'h70);
    cmd(8'h90);
    cmd(8'h00);
    expRd(8'h80, "R9 only status taken while busy");
    waitReady(-1, "R6 erase end");
    expRd(8'hC0, "R7 status shows ready");

    // R10 reset aborts a program
    cmd(8'h80); adr3(8'h20, 8'h00, 8'h00); dat(8'h00); cmd(8'h10);
    cmd(8'hFF);
    waitReady(RS, "R10 reset busy length");
    cmd(8'h00); adr3(8'h20, 8'h00, 8'h00);
    waitReady(RD, "R3 fetch busy length");
    expRd(8'hFF, "R10 aborted program left no data");

    // R11 write protect
    wpN = 1'b0;
    cmd(8'h80); adr3(8'h01, 8'h00, 8'h00); dat(8'h00); cmd(8'h10);
    check(rdyBsy == 1'b1, "R11 program refused", rdyBsy, 1);
    expRd(8'h41, "R11 status error and protect bits");
    cmd(8'h60); adr(8'h00); adr(8'h00); cmd(8'hD0);
    check(rdyBsy == 1'b1, "R11 erase refused", rdyBsy, 1);
    wpN = 1'b1;
    cmd(8'h00); adr3(8'h00, 8'h00, 8'h00);
    waitReady(RD, "R3 fetch busy length");
    expRd(8'h33, "R11 block0 not erased");
    expRd(8'hFF, "R11 column1 not programmed");

    // R8 ID sequence, R2 ignored cycle with chip enable high
    cmd(8'h90); adr(8'h00);
    expRd(8'hEC, "R8 first id byte");
    expRd(8'hA4, "R8 second id byte");
    wr(1'b1, 1'b0, 8'h70, 1'b1);
    expRd(8'h00, "R2 deselected write ignored, R8 third id byte");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    finishRun();
  end
endmodule